// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core (Eleven-Instruction Subset)

This block is a small 32-bit processor core that retires one instruction on every rising clock edge. It fetches from a read-only instruction store, reads two operands from a 32-by-32 register file, forms an operand from a sign-extended immediate where the format calls for one, runs a five-operation ALU, and either writes the result back, loads a word from a separate data store, or stores a word into it. Everything from fetch to write-back fits in one cycle. There is no pipeline, no branching and no trap logic.

The instruction store contents and the data store's power-on image are elaboration parameters. A synchronous reset returns the program counter to zero, clears the register file and restores the data store to its image. Two debug outputs expose the current program counter and the value produced by the instruction now executing, so an environment can follow execution cycle by cycle.

Top module: `rvm_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, every register becomes 0 and every data word is reloaded from `DMEM_IMAGE`.
- R2: When not in reset, the PC grows by 4 on every rising edge. The executing instruction is the instruction-store word at index PC[2+:log2(IMEM_WORDS)], wrapping modulo the depth, and `dbg_pc` shows the current PC.
- R3: Register-register instructions use opcode 0110011. With funct7 = 0000000, funct3 000 is add, 010 is set-less-than, 110 is or and 111 is and. With funct7 = 0100000, funct3 000 is subtract.
- R4: Register-immediate instructions use opcode 0010011 with the same funct3 codes (000 add, 010 set-less-than, 110 or, 111 and). The second operand is bits 31:20 sign-extended to 32 bits.
- R5: Set-less-than, in both its register and immediate forms, compares as two's-complement signed numbers and yields exactly 1 or 0.
- R6: A load (opcode 0000011, funct3 010) reads the data word whose index is (rs1 + sign-extended bits 31:20) modulo DMEM_WORDS and writes it to rd.
- R7: A store (opcode 0100011, funct3 010) writes rs2 on the rising edge into the word whose index is (rs1 + sign-extended {bits 31:25, bits 11:7}) modulo DMEM_WORDS. A load of that word in the next cycle returns the stored value.
- R8: Register 0 always reads as 0, and writes aimed at it are discarded.
- R9: A register write takes effect at the rising edge, so an instruction with rd equal to rs1 computes from the old value and the next instruction sees the new one.
- R10: Any other encoding has no effect on registers or data, and `dbg_result` is 0 while it executes. This covers other opcodes, other funct3 values, load or store with funct3 other than 010, and register-register funct7 other than the two listed.
- R11: `dbg_result` shows the ALU result for ALU instructions (also when rd is 0), the loaded word for a load, and the full 32-bit address sum for a store.
- R12: With the default images (data word 1 = 1), the five-instruction start-up program (load r1 from word 1; r2 = r1 + 2; store r2 to word 1; load r3 from word 1; r4 = r3 + 3) produces 6 as its fifth result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_result | output | 32 | Value produced by the executing instruction |

## Verification
Two pairs of functions can meet in the same cycle. In the first, the register write-back of one instruction lands in the register that the same instruction, or the next one, reads. In the second, a store updates a word that the following load fetches. A reset can also arrive while a store is executing, and the reset must win. Directed words near the start of the program force each of these collisions once, and the random part of the program draws registers from x0 to x7 and addresses from a narrow range so that they recur many times. Each cycle `dbg_pc` and `dbg_result` are judged against an instruction-level model in the bench, and a reset is injected at a randomly chosen cycle.

// File: rtl/rvm_pkg.sv
`timescale 1ns/1ps
package rvm_pkg;

    localparam int XLEN           = 32;
    localparam int NUM_REGS       = 32;
    localparam int REG_AW         = $clog2(NUM_REGS);
    localparam int DEF_IMEM_WORDS = 64;
    localparam int DEF_DMEM_WORDS = 64;
    localparam int IMM_W          = 12;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [REG_AW-1:0] reg_idx_t;

    // major opcodes recognised by the main decoder
    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    // function codes
    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_SLT  = 3'b010;
    localparam logic [2:0] F3_OR   = 3'b110;
    localparam logic [2:0] F3_AND  = 3'b111;
    localparam logic [2:0] F3_WORD = 3'b010;
    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_NONE,
        WB_ALU,
        WB_MEM
    } wb_sel_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_REG,
        CLS_IMM,
        CLS_LOAD,
        CLS_STORE
    } insn_cls_e;

    typedef struct packed {
        logic    valid;
        logic    mem_we;
        logic    use_imm;
        wb_sel_e wb_sel;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        reg_idx_t rd;
        reg_idx_t rs1;
        reg_idx_t rs2;
    } reg_sel_t;

    function automatic word_t imm_i(word_t insn);
        return {{(XLEN-IMM_W){insn[31]}}, insn[31:20]};
    endfunction

    function automatic word_t imm_s(word_t insn);
        return {{(XLEN-IMM_W){insn[31]}}, insn[31:25], insn[11:7]};
    endfunction

    function automatic word_t alu_eval(alu_op_e op, word_t a, word_t b);
        word_t r;
        case (op)
            ALU_ADD: r = a + b;
            ALU_SUB: r = a - b;
            ALU_AND: r = a & b;
            ALU_OR:  r = a | b;
            ALU_SLT: r = ($signed(a) < $signed(b)) ? word_t'(1) : '0;
            default: r = '0;
        endcase
        return r;
    endfunction

    // default start-up program: five words, the rest all-zero (undecoded)
    function automatic logic [DEF_IMEM_WORDS*XLEN-1:0] ref_program();
        logic [DEF_IMEM_WORDS*XLEN-1:0] img;
        img = '0;
        img[0*XLEN +: XLEN] = {12'd1, 5'd0, F3_WORD, 5'd1, OPC_LOAD};
        img[1*XLEN +: XLEN] = {12'd2, 5'd1, F3_ADD,  5'd2, OPC_IMM};
        img[2*XLEN +: XLEN] = {7'd0,  5'd2, 5'd0, F3_WORD, 5'd1, OPC_STORE};
        img[3*XLEN +: XLEN] = {12'd1, 5'd0, F3_WORD, 5'd3, OPC_LOAD};
        img[4*XLEN +: XLEN] = {12'd3, 5'd3, F3_ADD,  5'd4, OPC_IMM};
        return img;
    endfunction

    function automatic logic [DEF_DMEM_WORDS*XLEN-1:0] ref_data();
        logic [DEF_DMEM_WORDS*XLEN-1:0] img;
        img = '0;
        img[1*XLEN +: XLEN] = word_t'(1);
        return img;
    endfunction

endpackage

// File: rtl/rvm_fetch.sv
`timescale 1ns/1ps
module rvm_fetch import rvm_pkg::*; #(
    parameter int                       WORDS = DEF_IMEM_WORDS,
    parameter logic [WORDS*XLEN-1:0]    IMAGE = '0
) (
    input  logic  clk,
    input  logic  rst,
    output word_t pc,
    output word_t insn
);
    localparam int IAW = $clog2(WORDS);

    word_t rom [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_rom
        assign rom[g] = IMAGE[g*XLEN +: XLEN];
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc + word_t'(4);
    end

    assign insn = rom[pc[2 +: IAW]];

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pc == $past(pc) + word_t'(4)));

    assert_pc_home_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0));

endmodule

// File: rtl/rvm_decode.sv
`timescale 1ns/1ps
module rvm_decode import rvm_pkg::*; (
    input  word_t    insn,
    output ctrl_t    ctrl,
    output reg_sel_t sel,
    output word_t    imm
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    insn_cls_e  cls;
    alu_op_e    alu_op;
    logic       alu_ok;

    assign opc = insn[6:0];
    assign f3  = insn[14:12];
    assign f7  = insn[31:25];
    assign sel = '{rd: insn[11:7], rs1: insn[19:15], rs2: insn[24:20]};

    // main decoder: instruction class from the opcode
    always_comb begin
        cls = CLS_NONE;
        case (opc)
            OPC_REG:   cls = CLS_REG;
            OPC_IMM:   cls = CLS_IMM;
            OPC_LOAD:  if (f3 == F3_WORD) cls = CLS_LOAD;
            OPC_STORE: if (f3 == F3_WORD) cls = CLS_STORE;
            default:   cls = CLS_NONE;
        endcase
    end

    // ALU-operation decoder: funct3 and funct7 bit 30
    always_comb begin
        alu_op = ALU_ADD;
        alu_ok = 1'b0;
        case (cls)
            CLS_LOAD, CLS_STORE: alu_ok = 1'b1;
            CLS_REG, CLS_IMM: begin
                alu_ok = 1'b1;
                case (f3)
                    F3_ADD:  alu_op = (cls == CLS_REG && f7 == F7_ALT) ? ALU_SUB : ALU_ADD;
                    F3_SLT:  alu_op = ALU_SLT;
                    F3_OR:   alu_op = ALU_OR;
                    F3_AND:  alu_op = ALU_AND;
                    default: alu_ok = 1'b0;
                endcase
                if (cls == CLS_REG &&
                    !(f7 == F7_BASE || (f7 == F7_ALT && f3 == F3_ADD)))
                    alu_ok = 1'b0;
            end
            default: alu_ok = 1'b0;
        endcase
    end

    always_comb begin
        ctrl = '{valid: alu_ok, mem_we: 1'b0, use_imm: 1'b0,
                 wb_sel: WB_NONE, alu_op: alu_op};
        if (alu_ok) begin
            case (cls)
                CLS_REG:   ctrl.wb_sel = WB_ALU;
                CLS_IMM:   begin ctrl.use_imm = 1'b1; ctrl.wb_sel = WB_ALU; end
                CLS_LOAD:  begin ctrl.use_imm = 1'b1; ctrl.wb_sel = WB_MEM; end
                CLS_STORE: begin ctrl.use_imm = 1'b1; ctrl.mem_we = 1'b1; end
                default:   ctrl.valid = 1'b0;
            endcase
        end
    end

    // immediate generator: layout chosen by instruction class
    assign imm = (cls == CLS_STORE) ? imm_s(insn) : imm_i(insn);

endmodule

// File: rtl/rvm_regfile.sv
`timescale 1ns/1ps
module rvm_regfile import rvm_pkg::*; #(
    parameter int NREGS = NUM_REGS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  reg_idx_t waddr,
    input  word_t    wdata,
    input  reg_idx_t raddr_a,
    output word_t    rdata_a,
    input  reg_idx_t raddr_b,
    output word_t    rdata_b
);
    word_t regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we && waddr != '0) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

    assert_x0_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (raddr_a == '0) |-> (rdata_a == '0));

    assert_write_visible_R9: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> ((raddr_b != $past(waddr)) || (rdata_b == $past(wdata))));

endmodule

// File: rtl/rvm_dmem.sv
`timescale 1ns/1ps
module rvm_dmem import rvm_pkg::*; #(
    parameter int                    WORDS = DEF_DMEM_WORDS,
    parameter logic [WORDS*XLEN-1:0] IMAGE = '0,
    localparam int                   AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    output word_t         rdata
);
    word_t mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= IMAGE[i*XLEN +: XLEN];
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    assert_store_then_load_R7: assert property (@(posedge clk) disable iff (rst)
        we |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

    assert_image_restored_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdata == IMAGE[addr*XLEN +: XLEN]));

endmodule

// File: rtl/rvm_core.sv
`timescale 1ns/1ps
module rvm_core import rvm_pkg::*; #(
    parameter int                          IMEM_WORDS = DEF_IMEM_WORDS,
    parameter int                          DMEM_WORDS = DEF_DMEM_WORDS,
    parameter logic [IMEM_WORDS*XLEN-1:0]  IMEM_IMAGE = ref_program(),
    parameter logic [DMEM_WORDS*XLEN-1:0]  DMEM_IMAGE = ref_data()
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] dbg_pc,
    output logic [XLEN-1:0] dbg_result
);
    localparam int DAW = $clog2(DMEM_WORDS);

    word_t    pc_w, insn_w, imm_w;
    word_t    rs1_val, rs2_val, alu_b, alu_out, dm_rdata, wb_data;
    ctrl_t    ctrl;
    reg_sel_t sel;
    logic     rf_we, dm_we;

    rvm_fetch #(.WORDS(IMEM_WORDS), .IMAGE(IMEM_IMAGE)) u_fetch (
        .clk  (clk),
        .rst  (rst),
        .pc   (pc_w),
        .insn (insn_w)
    );

    rvm_decode u_decode (
        .insn (insn_w),
        .ctrl (ctrl),
        .sel  (sel),
        .imm  (imm_w)
    );

    rvm_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (sel.rd),
        .wdata   (wb_data),
        .raddr_a (sel.rs1),
        .rdata_a (rs1_val),
        .raddr_b (sel.rs2),
        .rdata_b (rs2_val)
    );

    assign alu_b   = ctrl.use_imm ? imm_w : rs2_val;
    assign alu_out = alu_eval(ctrl.alu_op, rs1_val, alu_b);
    assign dm_we   = ctrl.mem_we;

    rvm_dmem #(.WORDS(DMEM_WORDS), .IMAGE(DMEM_IMAGE)) u_dmem (
        .clk   (clk),
        .rst   (rst),
        .we    (dm_we),
        .addr  (alu_out[DAW-1:0]),
        .wdata (rs2_val),
        .rdata (dm_rdata)
    );

    assign rf_we      = (ctrl.wb_sel != WB_NONE);
    assign wb_data    = (ctrl.wb_sel == WB_MEM) ? dm_rdata : alu_out;
    assign dbg_pc     = pc_w;
    assign dbg_result = ctrl.valid ? wb_data : '0;

    assert_slt_boolean_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.valid && ctrl.alu_op == ALU_SLT) |-> (alu_out[XLEN-1:1] == '0));

    assert_undecoded_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !ctrl.valid |-> (!rf_we && !dm_we && dbg_result == '0));

endmodule

// File: tb/rvm_core_tb.sv
`timescale 1ns/1ps
module rvm_core_tb;

    localparam int NW = 64;

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rb, logic [4:0] ra,
                                          logic [2:0] f3, logic [4:0] rd);
        return {f7, rb, ra, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] ra, logic [2:0] f3,
                                          logic [4:0] rd, logic [6:0] opc);
        return {im, ra, f3, rd, opc};
    endfunction

    function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] rb, logic [4:0] ra);
        return {im[11:5], rb, ra, 3'b010, im[4:0], 7'b0100011};
    endfunction

    function automatic logic [NW*32-1:0] build_prog();
        logic [NW*32-1:0] p;
        logic [31:0] s, w;
        logic [4:0]  rd, ra, rb;
        logic [11:0] im;
        p = '0;
        s = 32'h1234_5678;
        for (int i = 0; i < NW; i++) begin
            s  = s * 32'd1664525 + 32'd1013904223;
            rd = {2'b00, s[18:16]};
            ra = {2'b00, s[21:19]};
            rb = {2'b00, s[24:22]};
            im = s[11:0];
            case (s[31:28])
                4'd0:  w = enc_r(7'h00, rb, ra, 3'b000, rd);
                4'd1:  w = enc_r(7'h20, rb, ra, 3'b000, rd);
                4'd2:  w = enc_r(7'h00, rb, ra, 3'b111, rd);
                4'd3:  w = enc_r(7'h00, rb, ra, 3'b110, rd);
                4'd4:  w = enc_r(7'h00, rb, ra, 3'b010, rd);
                4'd5:  w = enc_i(im, ra, 3'b000, rd, 7'b0010011);
                4'd6:  w = enc_i(im, ra, 3'b111, rd, 7'b0010011);
                4'd7:  w = enc_i(im, ra, 3'b110, rd, 7'b0010011);
                4'd8:  w = enc_i(im, ra, 3'b010, rd, 7'b0010011);
                4'd9:  w = enc_i({8'd0, s[3:0]}, ra, 3'b000, rd, 7'b0010011);
                4'd10, 4'd11: w = enc_i({6'd0, s[5:0]}, ra, 3'b010, rd, 7'b0000011);
                4'd12, 4'd13: w = enc_s({6'd0, s[5:0]}, rb, ra);
                4'd14: begin
                    case (s[13:12])
                        2'd0:    w = {s[31:7], 7'b1101111};
                        2'd1:    w = enc_i(im, ra, 3'b001, rd, 7'b0010011);
                        2'd2:    w = enc_i(im, ra, 3'b000, rd, 7'b0000011);
                        default: w = enc_r(7'h20, rb, ra, 3'b111, rd);
                    endcase
                end
                default: w = enc_i(12'hFFF - {8'd0, s[3:0]}, ra, 3'b000, rd, 7'b0010011);
            endcase
            case (i)
                0:  w = enc_i(12'd1, 5'd0, 3'b010, 5'd1, 7'b0000011);
                1:  w = enc_i(12'd2, 5'd1, 3'b000, 5'd2, 7'b0010011);
                2:  w = enc_s(12'd1, 5'd2, 5'd0);
                3:  w = enc_i(12'd1, 5'd0, 3'b010, 5'd3, 7'b0000011);
                4:  w = enc_i(12'd3, 5'd3, 3'b000, 5'd4, 7'b0010011);
                5:  w = enc_s(12'd9, 5'd2, 5'd0);
                6:  w = enc_i(12'd9, 5'd0, 3'b010, 5'd5, 7'b0000011);
                7:  w = enc_i(12'd1, 5'd5, 3'b000, 5'd5, 7'b0010011);
                8:  w = enc_i(12'd7, 5'd5, 3'b000, 5'd0, 7'b0010011);
                9:  w = enc_r(7'h00, 5'd0, 5'd0, 3'b000, 5'd6);
                10: w = enc_i(12'hFFF, 5'd0, 3'b000, 5'd7, 7'b0010011);
                11: w = enc_r(7'h00, 5'd0, 5'd7, 3'b010, 5'd6);
                12: w = enc_i(12'hFFE, 5'd7, 3'b010, 5'd6, 7'b0010011);
                13: w = enc_r(7'h20, 5'd7, 5'd0, 3'b000, 5'd6);
                14: w = 32'h0000_006F;
                default: ;
            endcase
            p[i*32 +: 32] = w;
        end
        return p;
    endfunction

    function automatic logic [NW*32-1:0] build_data();
        logic [NW*32-1:0] d;
        logic [31:0] s;
        s = 32'hCAFE_0001;
        for (int i = 0; i < NW; i++) begin
            s = s * 32'd22695477 + 32'd1;
            d[i*32 +: 32] = (i == 1) ? 32'd1 : s;
        end
        return d;
    endfunction

    localparam logic [NW*32-1:0] PROG = build_prog();
    localparam logic [NW*32-1:0] DATA = build_data();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc, dbg_result;
    int          n_chk  = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    rvm_core #(
        .IMEM_WORDS (NW),
        .DMEM_WORDS (NW),
        .IMEM_IMAGE (PROG),
        .DMEM_IMAGE (DATA)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .dbg_pc     (dbg_pc),
        .dbg_result (dbg_result)
    );

    // instruction-level model
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [NW];
    logic [31:0] m_pc;

    task automatic model_reset();
        m_pc = 32'd0;
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        for (int i = 0; i < NW; i++) m_mem[i] = DATA[i*32 +: 32];
    endtask

    task automatic model_step(output logic [31:0] exp, output string tag);
        logic [31:0] w, a, b, ii, is, r;
        logic [6:0]  opc, f7;
        logic [2:0]  f3;
        logic [4:0]  rd, ra, rb;
        logic        ok, wr;
        w   = PROG[int'(m_pc[7:2])*32 +: 32];
        opc = w[6:0];  f3 = w[14:12]; f7 = w[31:25];
        rd  = w[11:7]; ra = w[19:15]; rb = w[24:20];
        a   = m_reg[ra];
        b   = m_reg[rb];
        ii  = {{20{w[31]}}, w[31:20]};
        is  = {{20{w[31]}}, w[31:25], w[11:7]};
        ok = 1'b1; wr = 1'b1; r = 32'd0; tag = "R10";
        if (opc == 7'b0110011 && f7 == 7'h00 && f3 == 3'b000)      begin r = a + b; tag = "R3"; end
        else if (opc == 7'b0110011 && f7 == 7'h20 && f3 == 3'b000) begin r = a - b; tag = "R3"; end
        else if (opc == 7'b0110011 && f7 == 7'h00 && f3 == 3'b111) begin r = a & b; tag = "R3"; end
        else if (opc == 7'b0110011 && f7 == 7'h00 && f3 == 3'b110) begin r = a | b; tag = "R3"; end
        else if (opc == 7'b0110011 && f7 == 7'h00 && f3 == 3'b010) begin
            r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R5";
        end
        else if (opc == 7'b0010011 && f3 == 3'b000) begin r = a + ii; tag = "R4"; end
        else if (opc == 7'b0010011 && f3 == 3'b111) begin r = a & ii; tag = "R4"; end
        else if (opc == 7'b0010011 && f3 == 3'b110) begin r = a | ii; tag = "R4"; end
        else if (opc == 7'b0010011 && f3 == 3'b010) begin
            r = ($signed(a) < $signed(ii)) ? 32'd1 : 32'd0; tag = "R5";
        end
        else if (opc == 7'b0000011 && f3 == 3'b010) begin
            r = a + ii; r = m_mem[r[5:0]]; tag = "R6";
        end
        else if (opc == 7'b0100011 && f3 == 3'b010) begin
            r = a + is; m_mem[r[5:0]] = b; wr = 1'b0; tag = "R7";
        end
        else begin ok = 1'b0; wr = 1'b0; end
        exp = ok ? r : 32'd0;
        if (wr && rd != 5'd0) m_reg[rd] = r;
        m_pc = m_pc + 32'd4;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (pc %h)", req, act, exp, dbg_pc);
        end
    endtask

    initial begin
        int rst_at;
        int since;
        logic [31:0] exp;
        string tag;
        rst_at = 200 + int'($urandom(32'd77) % 32'd40);
        model_reset();
        rst = 1'b1;
        @(negedge clk);
        chk("R1", dbg_pc, 32'd0);
        @(negedge clk);
        chk("R1", dbg_pc, 32'd0);
        rst   = 1'b0;
        since = 0;
        for (int k = 0; k < 420; k++) begin
            if (k == rst_at) begin
                rst = 1'b1;
                @(negedge clk);
                chk("R1", dbg_pc, 32'd0);
                rst = 1'b0;
                model_reset();
                since = 0;
            end
            chk("R2", dbg_pc, m_pc);
            model_step(exp, tag);
            chk(tag, dbg_result, exp);
            case (since)
                0:  chk("R1", dbg_result, 32'd1);          // data image restored
                4:  chk("R12", dbg_result, 32'd6);
                5:  chk("R11", dbg_result, 32'd9);         // store shows address
                6:  chk("R7", dbg_result, 32'd3);          // load right after store
                7:  chk("R9", dbg_result, 32'd4);          // rd == rs1
                8:  chk("R11", dbg_result, 32'd11);        // result shown with rd = 0
                9:  chk("R8", dbg_result, 32'd0);          // x0 stayed zero
                11: chk("R5", dbg_result, 32'd1);          // -1 < 0 signed
                12: chk("R5", dbg_result, 32'd0);          // -1 < -2 false
                13: chk("R3", dbg_result, 32'd1);          // 0 - (-1)
                14: chk("R10", dbg_result, 32'd0);         // undecoded word
                default: ;
            endcase
            since++;
            @(negedge clk);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule